// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses from a local bus region onto a 64-bit link-side address space through a bank of equal-sized windows. Software programs one shared size code that fixes the span of every window, a translated base for each window (split over a lower and an upper register), and a global translate switch. Each window's lower register doubles as its enable: bit 0 turns the window on, and the bits above it hold the low half of the translated base.

For every request the block subtracts the region base from the local address, selects a window from the result, and either adds the offset inside that window to the window's translated base (a hit) or flags a miss and returns the local address unchanged, zero-extended to 64 bits. The result appears one clock after the request. The register port is a plain word-addressed read/write port with one cycle of read latency.

Top module: `xlat_window_top`

## Requirements
- R1: After reset every register reads as zero and `rsp_valid` is low.
- R2: The control register at byte offset 0x004 keeps all 32 written bits; read data appears in the cycle after `reg_rd_en` and `reg_rdata` is zero in any cycle that does not follow a read.
- R3: The size register at offset 0x030 keeps only bits [2:0] of a write; bits [31:3] read as zero.
- R4: Window n has its lower register at 0x200 + 8*n and its upper register at 0x204 + 8*n, each holding 32 written bits; any other offset reads zero and writes to it change no register.
- R5: Each request cycle (`req_valid` high) yields exactly one response cycle (`rsp_valid` high) in the next clock, in order, and no response appears without a request.
- R6: The selected window is (req_addr - REGION_BASE) >> (20 + size code), so each window spans 2^code MiB.
- R7: On a hit, `rsp_addr` = {upper register, lower register with bit 0 cleared} + ((req_addr - REGION_BASE) mod window span), and `rsp_miss` is low.
- R8: With control bit 1 clear, every request misses.
- R9: A request whose selected window has bit 0 of its lower register clear misses.
- R10: A request below REGION_BASE, or whose window index is NUM_WIN or more, misses; on any miss `rsp_addr` equals the request address zero-extended to 64 bits.
- R11: Changing the size code changes the window boundaries and the offset kept from the local address for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after a read |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local bus address to translate |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_miss | output | 1 | High when the request was not translated |

## Verification
The hardest situation to reach is a request that lands exactly at the edges of the window bank: the last byte of the last window, the first byte past it, and the byte just below the region base, all under more than one size code. The stimulus reprograms the size code between request groups and aims addresses at computed window boundaries, with only selected windows enabled, so that the index arithmetic, the offset mask and the range check are each hit on both sides of their limits. Back-to-back requests to different windows show that responses stay in order with no gap.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int        MB_SHIFT    = 20;
  localparam logic [11:0] CTRL_OFS  = 12'h004;
  localparam logic [11:0] SIZE_OFS  = 12'h030;
  localparam logic [11:0] WIN_OFS   = 12'h200;
  localparam int        WIN_STRIDE  = 8;
  localparam int        XLAT_EN_BIT = 1;
  localparam int        CODE_W      = 3;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/xlat_regfile.sv
module xlat_regfile
  import xlat_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int DW      = 32,
  parameter int RAW     = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [RAW-1:0]              addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [DW-1:0]               ctrl,
  output logic [CODE_W-1:0]           size_code,
  output logic [NUM_WIN-1:0][DW-1:0]  lo_regs,
  output logic [NUM_WIN-1:0][DW-1:0]  hi_regs
);
  localparam int IDXW    = $clog2(NUM_WIN);
  localparam int WIN_END = int'(WIN_OFS) + NUM_WIN * WIN_STRIDE;

  logic              ctrl_sel;
  logic              size_sel;
  logic              win_sel;
  logic              hi_sel;
  logic [IDXW-1:0]   win_idx;
  logic [RAW-1:0]    win_rel;
  logic [DW-1:0]     ctrl_q;
  logic [CODE_W-1:0] code_q;
  logic [DW-1:0]     rd_next;
  logic [DW-1:0]     rdata_q;

  // address decode
  always_comb begin
    ctrl_sel = (addr == RAW'(CTRL_OFS));
    size_sel = (addr == RAW'(SIZE_OFS));
    win_rel  = addr - RAW'(WIN_OFS);
    win_sel  = (addr >= RAW'(WIN_OFS)) && (int'(addr) < WIN_END) && (addr[1:0] == 2'b00);
    win_idx  = win_rel[IDXW+2:3];
    hi_sel   = addr[2];
  end

  // global registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && ctrl_sel) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (wr_en && size_sel) begin
      code_q <= wdata[CODE_W-1:0];
    end
  end

  // per-window offset registers
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic lo_we;
    logic hi_we;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    always_comb begin
      lo_we = wr_en && win_sel && (win_idx == IDXW'(w)) && !hi_sel;
      hi_we = wr_en && win_sel && (win_idx == IDXW'(w)) &&  hi_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
      end else if (lo_we) begin
        lo_q <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
      end else if (hi_we) begin
        hi_q <= wdata;
      end
    end

    assign lo_regs[w] = lo_q;
    assign hi_regs[w] = hi_q;
  end

  // read path
  always_comb begin
    rd_next = '0;
    if (ctrl_sel) begin
      rd_next = ctrl_q;
    end else if (size_sel) begin
      rd_next = DW'(code_q);
    end else if (win_sel) begin
      rd_next = hi_sel ? hi_regs[win_idx] : lo_regs[win_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_en ? rd_next : '0;
    end
  end

  assign rdata     = rdata_q;
  assign ctrl      = ctrl_q;
  assign size_code = code_q;
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter int          NUM_WIN     = 32,
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
  input  logic [AW-1:0]               req_addr,
  input  logic                        xlat_en,
  input  logic [CODE_W-1:0]           size_code,
  input  logic [NUM_WIN-1:0][DW-1:0]  lo_regs,
  input  logic [NUM_WIN-1:0][DW-1:0]  hi_regs,
  output logic                        hit,
  output logic [2*DW-1:0]             xaddr
);
  localparam int IDXW = $clog2(NUM_WIN);
  localparam int OW   = 2 * DW;

  logic            below;
  logic            in_range;
  logic [4:0]      shamt;
  logic [AW-1:0]   ofs;
  logic [AW-1:0]   idx_full;
  logic [AW-1:0]   mask;
  logic [AW-1:0]   low;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   sel_lo;
  logic [DW-1:0]   sel_hi;
  logic [OW-1:0]   base;
  logic [OW-1:0]   sum;

  always_comb begin
    below    = req_addr < AW'(REGION_BASE);
    ofs      = req_addr - AW'(REGION_BASE);
    shamt    = 5'(MB_SHIFT) + 5'(size_code);
    idx_full = ofs >> shamt;
    in_range = !below && (idx_full < AW'(NUM_WIN));
    idx      = idx_full[IDXW-1:0];
    mask     = (AW'(1) << shamt) - AW'(1);
    low      = ofs & mask;
    sel_lo   = lo_regs[idx];
    sel_hi   = hi_regs[idx];
    base     = {sel_hi, sel_lo[DW-1:1], 1'b0};
    sum      = base + OW'(low);
    hit      = in_range && sel_lo[0] && xlat_en;
    xaddr    = hit ? sum : OW'(req_addr);
  end
endmodule

// File: rtl/xlat_window_top.sv
module xlat_window_top
  import xlat_pkg::*;
#(
  parameter int          NUM_WIN     = 32,
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter int          RAW         = 12,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic            reg_rd_en,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  output logic            rsp_valid,
  output logic [2*DW-1:0] rsp_addr,
  output logic            rsp_miss
);
  localparam int OW = 2 * DW;

  logic                       rst_sync_n;
  logic [DW-1:0]              ctrl;
  logic [CODE_W-1:0]          size_code;
  logic [NUM_WIN-1:0][DW-1:0] lo_regs;
  logic [NUM_WIN-1:0][DW-1:0] hi_regs;
  logic                       xlat_en;
  logic                       hit;
  logic [OW-1:0]              xaddr;

  logic          valid_q;
  logic          miss_q;
  logic          miss_d;
  logic [OW-1:0] addr_q;
  logic [OW-1:0] addr_d;

  xlat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xlat_regfile #(
    .NUM_WIN (NUM_WIN),
    .DW      (DW),
    .RAW     (RAW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr_en),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .ctrl      (ctrl),
    .size_code (size_code),
    .lo_regs   (lo_regs),
    .hi_regs   (hi_regs)
  );

  assign xlat_en = ctrl[XLAT_EN_BIT];

  xlat_lookup #(
    .NUM_WIN     (NUM_WIN),
    .AW          (AW),
    .DW          (DW),
    .REGION_BASE (REGION_BASE)
  ) u_lookup (
    .req_addr  (req_addr),
    .xlat_en   (xlat_en),
    .size_code (size_code),
    .lo_regs   (lo_regs),
    .hi_regs   (hi_regs),
    .hit       (hit),
    .xaddr     (xaddr)
  );

  // next-state for the response stage
  always_comb begin
    addr_d = xaddr;
    miss_d = !hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      miss_q <= 1'b0;
    end else if (req_valid) begin
      addr_q <= addr_d;
      miss_q <= miss_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_addr  = addr_q;
  assign rsp_miss  = miss_q;
endmodule

// File: rtl/xlat_window_chk.sv
module xlat_window_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic [2*DW-1:0] rsp_addr,
  input logic            rsp_miss,
  input logic            reg_rd_en,
  input logic [DW-1:0]   reg_rdata,
  input logic            xlat_en
);
  // R5: a request produces a response in the next cycle
  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R5: no response without a request
  p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8: global switch off forces a miss
  p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_en) |=> rsp_miss);

  // R10: a miss returns the request address unchanged
  p_miss_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_addr == {{(2*DW-AW){1'b0}}, $past(req_addr)}));

  // R2: read data is zero when no read was issued
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> (reg_rdata == '0));
endmodule

bind xlat_window_top xlat_window_chk #(
  .AW (AW),
  .DW (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_miss  (rsp_miss),
  .reg_rd_en (reg_rd_en),
  .reg_rdata (reg_rdata),
  .xlat_en   (xlat_en)
);

// File: tb/xlat_window_top_tb.sv
module xlat_window_top_tb;
  localparam int          NW   = 32;
  localparam logic [31:0] BASE = 32'h4000_0000;

  typedef struct {
    logic [63:0] addr;
    logic        miss;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic        reg_rd_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        rsp_miss;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  exp_t        q[$];
  logic [31:0] sh_ctrl;
  logic [2:0]  sh_code;
  logic [31:0] sh_lo[NW];
  logic [31:0] sh_hi[NW];

  xlat_window_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_miss  (rsp_miss)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, output logic [63:0] ea, output logic em);
    logic [31:0] ofs;
    logic [31:0] idx;
    logic [31:0] low;
    int          sh;
    sh  = 20 + int'(sh_code);
    ofs = a - BASE;
    idx = ofs >> sh;
    low = ofs & ((32'd1 << sh) - 32'd1);
    if (a < BASE || idx >= NW || !sh_ctrl[1] || !sh_lo[idx[4:0]][0]) begin
      em = 1'b1;
      ea = {32'd0, a};
    end else begin
      em = 1'b0;
      ea = {sh_hi[idx[4:0]], sh_lo[idx[4:0]] & 32'hFFFF_FFFE} + {32'd0, low};
    end
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 12'h004) sh_ctrl = d;
    else if (a == 12'h030) sh_code = d[2:0];
    else if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00) begin
      if (a[2]) sh_hi[(a - 12'h200) >> 3] = d;
      else      sh_lo[(a - 12'h200) >> 3] = d;
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd_en = 1'b1;
    reg_addr  = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic push_exp(input logic [31:0] a, input string tag);
    exp_t e;
    model(a, e.addr, e.miss);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    push_exp(a, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_burst(input logic [31:0] a0, input logic [31:0] a1, input logic [31:0] a2, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a0;
    push_exp(a0, tag);
    @(negedge clk);
    req_addr  = a1;
    push_exp(a1, tag);
    @(negedge clk);
    req_addr  = a2;
    push_exp(a2, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5 unexpected response", rsp_addr, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_miss == e.miss, {e.tag, " miss"}, 64'(rsp_miss), 64'(e.miss));
        chk(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    reg_wr_en = 1'b0;
    reg_rd_en = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    req_valid = 1'b0;
    req_addr  = '0;
    sh_ctrl   = '0;
    sh_code   = '0;
    for (int i = 0; i < NW; i++) begin
      sh_lo[i] = '0;
      sh_hi[i] = '0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd_chk(12'h004, 32'd0, "R1 control reset");
    rd_chk(12'h030, 32'd0, "R1 size reset");
    rd_chk(12'h200, 32'd0, "R1 window0 lower reset");
    rd_chk(12'h2FC, 32'd0, "R1 window31 upper reset");

    // R2: control register full width
    wr(12'h004, 32'h1234_5679);
    rd_chk(12'h004, 32'h1234_5679, "R2 control readback");
    @(negedge clk);
    chk(reg_rdata == 32'd0, "R2 rdata idle", 64'(reg_rdata), 64'd0);

    // R3: size register keeps three bits
    wr(12'h030, 32'hFFFF_FFFA);
    rd_chk(12'h030, 32'd2, "R3 size code masked");
    wr(12'h030, 32'd0);

    // R4: window registers and unmapped offsets
    wr(12'h228, 32'h8000_0001);
    wr(12'h22C, 32'h0000_0012);
    rd_chk(12'h228, 32'h8000_0001, "R4 window5 lower");
    rd_chk(12'h22C, 32'h0000_0012, "R4 window5 upper");
    wr(12'h00C, 32'hDEAD_BEEF);
    rd_chk(12'h00C, 32'd0, "R4 unmapped reads zero");
    wr(12'h229, 32'hDEAD_BEEF);
    rd_chk(12'h228, 32'h8000_0001, "R4 misaligned write ignored");
    wr(12'h300, 32'hCAFE_0001);
    rd_chk(12'h300, 32'd0, "R4 past last window reads zero");
    rd_chk(12'h004, 32'h1234_5679, "R4 control untouched");

    // R8: global translate off
    send(BASE + 32'h0050_1234, "R8 global off miss");

    // R6 R7: hit in window 5 with 1 MiB windows
    wr(12'h004, sh_ctrl | 32'h2);
    send(BASE + 32'h0050_1234, "R7 hit window5");
    send(BASE + 32'h005F_FFFF, "R6 last byte window5");

    // R9: disabled neighbour window
    wr(12'h220, 32'h7000_0000);
    send(BASE + 32'h0040_0010, "R9 window4 disabled");

    // R10: out of range
    send(BASE + 32'h0200_0000, "R10 index equals window count");
    send(BASE - 32'd1, "R10 below base");

    // R11: 8 MiB windows
    wr(12'h030, 32'd3);
    wr(12'h200, 32'h0000_0001);
    wr(12'h204, 32'h0000_ABCD);
    wr(12'h2F8, 32'h1000_0001);
    wr(12'h2FC, 32'h0000_0007);
    send(BASE + 32'h0012_3456, "R11 window0 with code3");
    send(BASE + 32'h0287_FFFF, "R11 window5 with code3");
    send(BASE + 32'h0FFF_FFFF, "R10 last byte of window31");
    send(BASE + 32'h1000_0000, "R10 past window31 with code3");

    // R5: back-to-back requests
    send_burst(BASE + 32'h0000_0040, BASE + 32'h0F80_0000, BASE + 32'h0040_0000, "R5 burst");

    // R8: switch off again
    wr(12'h004, sh_ctrl & ~32'h2);
    send(BASE + 32'h0012_3456, "R8 off after hit");

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R5 all responses seen", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule